// File: doc/BRIEF.md
# Streaming Test Packet Generator

This block drives a stream master port with packets of synthetic test data. Generation runs while an enable input is high. A beat moves to the sink only on a clock edge where both the valid and ready lines are high. A length input sets how many beats make up a packet, and a two-bit selector picks the payload sequence. The block uses the same beat counter for two jobs: it tracks where the current beat sits in the packet, and it supplies the payload value in counting mode. In that mode the payload runs 1, 2, 3, … and starts again at 1 with each new packet.

The length and pattern inputs are captured when the first beat of a packet is loaded. They apply to that whole packet, so software or a test sequencer can change them at any time without splitting a packet. The constant pattern emits the parameter `FILL_WORD`. The alternating pattern fills every byte of the word with 0x55 on odd beats and with 0xAA on even beats.

Top module: `axis_pktgen`

## Requirements
- R1: While `rst` is high, and after it for as long as `gen_en` stays low, `m_axis_tvalid` is 0.
- R2: With `pat_sel` = 2'b00 or 2'b11 (count), beat k of a packet (k counted from 1) carries the value k, zero-extended, on `m_axis_tdata`.
- R3: `m_axis_tlast` is 1 exactly on the beat whose index equals the packet length captured for that packet. The beat after it is index 1 of a new packet.
- R4: A beat transfers only on an edge where `m_axis_tvalid` and `m_axis_tready` are both 1. While valid is high and ready is low, valid stays high and `m_axis_tdata` and `m_axis_tlast` hold their values.
- R5: With `pat_sel` = 2'b01 (constant), every beat carries `FILL_WORD` (default 32'h5A5A_F00D).
- R6: With `pat_sel` = 2'b10 (alternating), odd-index beats carry 0x55 in every byte and even-index beats carry 0xAA in every byte.
- R7: `pkt_len` and `pat_sel` are sampled when beat 1 of a packet is loaded. Changes made later in that packet take effect only from the next packet.
- R8: A `pkt_len` of 0 gives one-beat packets: every beat has index 1 and `m_axis_tlast` = 1.
- R9: When `gen_en` falls, no new beat is presented once the held beat has been accepted. When `gen_en` rises again, the packet continues from the next beat index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Allows new beats to be loaded |
| pkt_len | input | LEN_W | Beats per packet (0 means 1) |
| pat_sel | input | 2 | Payload pattern selector |
| m_axis_tready | input | 1 | Sink ready |
| m_axis_tvalid | output | 1 | Beat valid |
| m_axis_tdata | output | DATA_W | Beat payload |
| m_axis_tlast | output | 1 | Final beat of the packet |

## Verification
The hardest case to reach is a change of configuration in the middle of a packet. The new length and pattern must stay out of the packet in flight and must appear in full on the next one. To reach it, the stimulus waits until a given beat has been accepted, then switches both pattern and length while the remaining beats are still queued.

A second hard case is pausing inside a packet. The enable is dropped in the half cycle before a mid-packet beat is accepted, and the stimulus then checks that the next packet resumes at the following index. Random ready backpressure runs through most scenarios, so stalls land on first, middle and last beats.

// File: rtl/axis_pktgen_pkg.sv
package axis_pktgen_pkg;
  typedef enum logic [1:0] {
    PAT_COUNT  = 2'b00,
    PAT_FILL   = 2'b01,
    PAT_TOGGLE = 2'b10,
    PAT_COUNT2 = 2'b11
  } pat_e;
endpackage

// File: rtl/axis_pktgen_beatctr.sv
module axis_pktgen_beatctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [LEN_W-1:0] len_eff,
  output logic [LEN_W-1:0] beat,
  output logic             at_end
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  assign at_end = (beat == len_eff);

  always_ff @(posedge clk) begin
    if (rst)
      beat <= ONE;
    else if (adv)
      beat <= at_end ? ONE : beat + ONE;
  end

  // R2: the index never leaves the range 1.. so the payload never shows 0
  assert_beat_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    beat != '0);

  // R3: the beat after the last one is index 1 again
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && at_end) |=> (beat == ONE));
endmodule

// File: rtl/axis_pktgen_patsel.sv
module axis_pktgen_patsel
  import axis_pktgen_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              LEN_W     = 8,
  parameter logic [DATA_W-1:0] FILL_WORD = 32'h5A5A_F00D
) (
  input  pat_e              mode,
  input  logic [LEN_W-1:0]  beat,
  output logic [DATA_W-1:0] data
);
  localparam int NBYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] ODD_WORD  = {NBYTES{8'h55}};
  localparam logic [DATA_W-1:0] EVEN_WORD = {NBYTES{8'hAA}};

  always_comb begin
    unique case (mode)
      PAT_FILL:   data = FILL_WORD;
      PAT_TOGGLE: data = beat[0] ? ODD_WORD : EVEN_WORD;
      default:    data = DATA_W'(beat);
    endcase
  end
endmodule

// File: rtl/axis_pktgen.sv
module axis_pktgen
  import axis_pktgen_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              LEN_W     = 8,
  parameter logic [DATA_W-1:0] FILL_WORD = 32'h5A5A_F00D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_en,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [1:0]        pat_sel,
  input  logic              m_axis_tready,
  output logic              m_axis_tvalid,
  output logic [DATA_W-1:0] m_axis_tdata,
  output logic              m_axis_tlast
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0]  beat, len_q, len_in, len_eff;
  logic              at_end, slot_free, load, first;
  pat_e              pat_q, pat_cur;
  logic [DATA_W-1:0] next_data;

  assign slot_free = !m_axis_tvalid || m_axis_tready;
  assign load      = slot_free && gen_en;
  assign first     = (beat == ONE);
  assign len_in    = (pkt_len == '0) ? ONE : pkt_len;
  assign len_eff   = first ? len_in : len_q;
  assign pat_cur   = first ? pat_e'(pat_sel) : pat_q;

  axis_pktgen_beatctr #(.LEN_W(LEN_W)) ctr_i (
    .clk(clk), .rst(rst), .adv(load), .len_eff(len_eff),
    .beat(beat), .at_end(at_end)
  );

  axis_pktgen_patsel #(.DATA_W(DATA_W), .LEN_W(LEN_W), .FILL_WORD(FILL_WORD)) pat_i (
    .mode(pat_cur), .beat(beat), .data(next_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_axis_tvalid <= 1'b0;
      m_axis_tdata  <= '0;
      m_axis_tlast  <= 1'b0;
      len_q         <= ONE;
      pat_q         <= PAT_COUNT;
    end else if (slot_free) begin
      m_axis_tvalid <= gen_en;
      if (gen_en) begin
        m_axis_tdata <= next_data;
        m_axis_tlast <= at_end;
        if (first) begin
          len_q <= len_in;
          pat_q <= pat_e'(pat_sel);
        end
      end
    end
  end

  // R4: a stalled beat is held unchanged
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (m_axis_tvalid && !m_axis_tready) |=>
      (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast)));

  // R1 and R9: with enable low, valid goes low once the slot frees
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!gen_en && slot_free) |=> !m_axis_tvalid);

  // R7: the captured pattern stays put inside a packet
  assert_pat_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (m_axis_tvalid && m_axis_tready && !m_axis_tlast) |=> $stable(pat_q));

  // R8: the captured length is never zero
  assert_len_floor_R8: assert property (@(posedge clk) disable iff (rst)
    len_q != '0);
endmodule

// File: tb/axis_pktgen_tb_top.sv
module axis_pktgen_tb_top;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 8;
  localparam logic [DATA_W-1:0] FILL = 32'h5A5A_F00D;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              gen_en = 1'b0;
  logic [LEN_W-1:0]  pkt_len = 8'd4;
  logic [1:0]        pat_sel = 2'b00;
  logic              tready = 1'b1;
  logic              tvalid, tlast;
  logic [DATA_W-1:0] tdata;

  always #4 clk = ~clk;

  axis_pktgen #(.DATA_W(DATA_W), .LEN_W(LEN_W), .FILL_WORD(FILL)) dut_i (
    .clk(clk), .rst(rst), .gen_en(gen_en), .pkt_len(pkt_len), .pat_sel(pat_sel),
    .m_axis_tready(tready), .m_axis_tvalid(tvalid), .m_axis_tdata(tdata),
    .m_axis_tlast(tlast)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // backpressure driver: 0 = always ready, 1 = random
  int          bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tready = (bp_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
  end

  function automatic logic [DATA_W-1:0] exp_data(input logic [1:0] p, input int idx);
    case (p)
      2'b01:   return FILL;
      2'b10:   return idx[0] ? 32'h5555_5555 : 32'hAAAA_AAAA;
      default: return DATA_W'(idx);
    endcase
  endfunction

  // reference model and monitor, sampled at the falling edge
  int          m_idx = 1;
  int          m_len = 1;
  logic [1:0]  m_pat = 2'b00;
  int          pkt_done = 0;
  int          beats_in_pkt = 0;
  int          last_pkt_beats = 0;
  bit          prev_stall = 0;
  logic [DATA_W-1:0] prev_data;
  logic        prev_last;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(tvalid && tdata == prev_data && tlast == prev_last, "R4",
              "stalled beat changed", {tdata, 31'd0, tlast}, {prev_data, 31'd0, prev_last});
      prev_stall = tvalid && !tready;
      prev_data  = tdata;
      prev_last  = tlast;
      if (tvalid && tready) begin
        if (m_idx == 1) begin
          m_len = (pkt_len == 0) ? 1 : int'(pkt_len);
          m_pat = pat_sel;
        end
        check(tdata == exp_data(m_pat, m_idx),
              (m_pat == 2'b01) ? "R5" : (m_pat == 2'b10) ? "R6" : "R2",
              "payload", 64'(tdata), 64'(exp_data(m_pat, m_idx)));
        check(tlast == (m_idx == m_len), "R3", "last flag",
              64'(tlast), 64'(m_idx == m_len));
        beats_in_pkt++;
        if (m_idx == m_len) begin
          m_idx = 1;
          pkt_done++;
          last_pkt_beats = beats_in_pkt;
          beats_in_pkt = 0;
        end else begin
          m_idx++;
        end
      end
    end
  end

  // enable until n more packets finish, dropping enable ahead of the final beat
  task automatic run_pkts(input int n);
    int target;
    target = pkt_done + n;
    @(negedge clk); #1;
    gen_en = 1'b1;
    do begin
      @(negedge clk); #1;
    end while (!(tvalid && tready && tlast && pkt_done >= target));
    gen_en = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!tvalid, "R9", "valid after stop", 64'(tvalid), 64'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!tvalid, "R1", "valid in reset", 64'(tvalid), 64'd0);
    @(negedge clk); #1; rst = 1'b0;
    repeat (8) begin
      @(negedge clk);
      check(!tvalid, "R1", "valid with enable low", 64'(tvalid), 64'd0);
    end
  endtask

  task automatic t_count();
    int start;
    pkt_len = 8'd5; pat_sel = 2'b00; bp_mode = 0;
    start = pkt_done;
    run_pkts(3);
    check(pkt_done - start == 3, "R3", "packet count", 64'(pkt_done - start), 64'd3);
    check(last_pkt_beats == 5, "R3", "packet size", 64'(last_pkt_beats), 64'd5);
  endtask

  task automatic t_backpressure();
    pkt_len = 8'd7; pat_sel = 2'b11; bp_mode = 1;
    run_pkts(4);
    check(last_pkt_beats == 7, "R4", "size under stalls", 64'(last_pkt_beats), 64'd7);
  endtask

  task automatic t_fill();
    pkt_len = 8'd4; pat_sel = 2'b01; bp_mode = 1;
    run_pkts(2);
    check(last_pkt_beats == 4, "R5", "fill packet size", 64'(last_pkt_beats), 64'd4);
  endtask

  task automatic t_toggle();
    pkt_len = 8'd6; pat_sel = 2'b10; bp_mode = 1;
    run_pkts(2);
    check(last_pkt_beats == 6, "R6", "toggle packet size", 64'(last_pkt_beats), 64'd6);
  endtask

  task automatic t_len_zero();
    pkt_len = 8'd0; pat_sel = 2'b00; bp_mode = 0;
    run_pkts(3);
    check(last_pkt_beats == 1, "R8", "zero-length size", 64'(last_pkt_beats), 64'd1);
  endtask

  task automatic t_mid_change();
    int start;
    pkt_len = 8'd8; pat_sel = 2'b00; bp_mode = 1;
    start = pkt_done;
    @(negedge clk); #1;
    gen_en = 1'b1;
    do begin
      @(negedge clk); #1;
    end while (m_idx != 4);
    pat_sel = 2'b10; pkt_len = 8'd3;
    do begin
      @(negedge clk); #1;
    end while (pkt_done == start);
    check(last_pkt_beats == 8, "R7", "old length kept", 64'(last_pkt_beats), 64'd8);
    do begin
      @(negedge clk); #1;
    end while (!(tvalid && tready && tlast && pkt_done >= start + 1));
    gen_en = 1'b0;
    repeat (3) @(negedge clk);
    check(last_pkt_beats == 3, "R7", "new length used", 64'(last_pkt_beats), 64'd3);
    check(m_pat == 2'b10, "R7", "new pattern used", 64'(m_pat), 64'd2);
  endtask

  task automatic t_pause();
    pkt_len = 8'd6; pat_sel = 2'b00; bp_mode = 0;
    @(negedge clk); #1;
    gen_en = 1'b1;
    do begin
      @(negedge clk); #1;
    end while (!(tvalid && tready && m_idx == 3));
    gen_en = 1'b0;
    repeat (6) begin
      @(negedge clk);
      check(!tvalid, "R9", "valid while paused", 64'(tvalid), 64'd0);
    end
    check(m_idx == 3, "R9", "paused index", 64'(m_idx), 64'd3);
    run_pkts(1);
    check(last_pkt_beats == 6, "R9", "resumed packet size", 64'(last_pkt_beats), 64'd6);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_count();
    t_backpressure();
    t_fill();
    t_toggle();
    t_len_zero();
    t_mid_change();
    t_pause();
    finish_run();
  end
endmodule